// File: doc/BRIEF.md
# Comparator Timer Channel With Periodic Reload

This block is one channel of a high-resolution event timer. A 64-bit main counter advances by one each clock while a global run bit is set. The channel compares the counter against a 64-bit target. When they meet, it latches an interrupt status bit and can signal an interrupt. In periodic mode it then moves its target forward by a stored period, so it fires again at a fixed rate.

Software reaches every register over one write port and one combinational read port. A write is 32 bits wide, or 64 bits with a wide flag. Each 64-bit quantity occupies an 8-byte-aligned pair of words: the low half at the aligned offset and the high half at offset +4. A wide write to the aligned offset fills both halves in one cycle. In periodic mode a self-clearing "load target" bit decides what a target write does. With the bit set, the write goes into both the target and the period. With the bit clear, only the period changes, and the new rate applies from the next match. The per-channel enable gates only the interrupt output. Matching, status and reload run whatever its value, and every target value, including all ones, can be reached.

Byte offsets: 0x00 run control (bit 0 = counter runs); 0x04 status (bit 0, write 1 to clear); 0x08/0x0C counter low/high; 0x10 channel config (bit 0 interrupt enable, bit 1 periodic, bit 2 load target, bit 3 narrow 32-bit mode, bit 4 level type when 1, pulse type when 0); 0x18/0x1C target low/high; 0x20/0x24 period low/high (read only).

Top module: `evt_timer_channel`

## Requirements
- R1: After reset every register reads 0. While run bit 0 of offset 0x00 is 1 the counter rises by exactly one per clock; while it is 0 the counter holds.
- R2: In one-shot mode (config bit 1 = 0), status bit 0 becomes 1 on the clock edge at which the counter takes the target value, and the target is left unchanged.
- R3: In periodic mode with load-target bit 2 = 0, a 32-bit write to a target half changes only that half of the period; the target stays as it was.
- R4: In periodic mode with bit 2 = 1, a 32-bit target write updates that half of both target and period, and bit 2 reads 0 afterwards. A following high-half write therefore reaches only the period.
- R5: A wide write to offset 0x18 with bit 2 = 1 loads all 64 bits of target and period in one cycle, and bit 2 is cleared only after that write.
- R6: On a periodic match the period is added to the target, so the first match happens at the written target value and later ones follow at period steps.
- R7: The high half of the period never exceeds 0x7FFFFFFF; larger written values are clamped to it, while a target high half written with bit 2 = 1 keeps the raw value.
- R8: In level mode (bit 4 = 1) the interrupt output equals status AND enable bit 0. A channel with enable 0 never raises it, although its status still sets.
- R9: In pulse mode (bit 4 = 0) an enabled channel raises the interrupt output for exactly one clock per match.
- R10: A target of all ones matches when the counter reaches all ones.
- R11: In narrow mode (bit 3 = 1) only the low 32 bits of counter and target take part in matching, and any upper target bits are ignored.
- R12: Writing 1 to status bit 0 clears it; writing 0 leaves it set.
- R13: The counter can be loaded by halves; a 32-bit write to 0x0C replaces only its high word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_wide | input | 1 | Write carries 64 bits to an aligned offset |
| bus_addr | input | ADDR_W | Byte offset of the write |
| bus_wdata | input | TMR_W | Write data; 32-bit writes use the low half |
| rd_addr | input | ADDR_W | Byte offset of the read |
| rd_data | output | TMR_W/2 | Combinational read data |
| irq | output | 1 | Interrupt output |

## Verification
Register writes take effect at the clock edge that accepts them, so their readback is checked on the next falling edge. A match is seen at the edge where the counter takes the target value. Status and both interrupt types change at that same edge, which is N edges after the run bit is accepted for a target N above the counter. The checks sample one edge before and at that edge. The periodic target is predicted by a function of start value, offset, period and the number of edges the counter ran, with the run-disable edge counted as one of them.

// File: rtl/evt_pkg.sv
package evt_pkg;

    // Channel configuration; packed so that en is bit 0 of the config word.
    typedef struct packed {
        logic lvl;       // bit 4: level type when 1
        logic mode32;    // bit 3: narrow matching
        logic setval;    // bit 2: next target write loads the target
        logic periodic;  // bit 1: periodic reload
        logic en;        // bit 0: interrupt enable
    } chan_cfg_t;

    localparam int unsigned CFG_BITS = $bits(chan_cfg_t);

    // Byte offsets; bit 2 selects the high word of a 64-bit pair.
    localparam int unsigned OFS_RUN    = 'h00;
    localparam int unsigned OFS_STAT   = 'h04;
    localparam int unsigned OFS_CNT_LO = 'h08;
    localparam int unsigned OFS_CNT_HI = 'h0C;
    localparam int unsigned OFS_CFG    = 'h10;
    localparam int unsigned OFS_CMP_LO = 'h18;
    localparam int unsigned OFS_CMP_HI = 'h1C;
    localparam int unsigned OFS_PER_LO = 'h20;
    localparam int unsigned OFS_PER_HI = 'h24;

endpackage

// File: rtl/evt_match.sv
module evt_match #(
    parameter int unsigned W = 64
) (
    input  logic [W-1:0] cnt_next,
    input  logic [W-1:0] target,
    input  logic         narrow,
    output logic         hit
);
    localparam int unsigned H = W / 2;

    always_comb begin
        if (narrow) hit = (cnt_next[H-1:0] == target[H-1:0]);
        else        hit = (cnt_next == target);
    end
endmodule

// File: rtl/evt_reload.sv
module evt_reload #(
    parameter int unsigned W = 64
) (
    input  logic [W-1:0] target,
    input  logic [W-1:0] period,
    input  logic         narrow,
    output logic [W-1:0] target_next
);
    localparam int unsigned H = W / 2;

    always_comb begin
        if (narrow) target_next = {target[W-1:H], target[H-1:0] + period[H-1:0]};
        else        target_next = target + period;
    end
endmodule

// File: rtl/evt_wr_merge.sv
module evt_wr_merge #(
    parameter int unsigned W          = 64,
    parameter logic [W/2-1:0] PER_HI_MAX = 32'h7FFF_FFFF
) (
    input  logic [W-1:0] tgt_base,
    input  logic [W-1:0] per_base,
    input  logic         we_lo,
    input  logic         we_hi,
    input  logic [W-1:0] wdata,
    input  logic         periodic,
    input  logic         load_tgt,
    output logic [W-1:0] tgt_new,
    output logic [W-1:0] per_new
);
    localparam int unsigned H = W / 2;

    logic [H-1:0] hi_clamped;
    logic         tgt_open;

    always_comb begin
        hi_clamped = (wdata[W-1:H] > PER_HI_MAX) ? PER_HI_MAX : wdata[W-1:H];
        tgt_open   = !periodic || load_tgt;
        tgt_new    = tgt_base;
        per_new    = per_base;
        if (we_lo) begin
            if (tgt_open) tgt_new[H-1:0] = wdata[H-1:0];
            if (periodic) per_new[H-1:0] = wdata[H-1:0];
        end
        if (we_hi) begin
            if (tgt_open) tgt_new[W-1:H] = wdata[W-1:H];
            if (periodic) per_new[W-1:H] = hi_clamped;
        end
    end
endmodule

// File: rtl/evt_timer_channel.sv
module evt_timer_channel
    import evt_pkg::*;
#(
    parameter int unsigned TMR_W      = 64,
    parameter int unsigned ADDR_W     = 8,
    parameter logic [TMR_W/2-1:0] PER_HI_MAX = 32'h7FFF_FFFF
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_we,
    input  logic                 bus_wide,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [TMR_W-1:0]     bus_wdata,
    input  logic [ADDR_W-1:0]    rd_addr,
    output logic [TMR_W/2-1:0]   rd_data,
    output logic                 irq
);
    localparam int unsigned H = TMR_W / 2;

    typedef struct packed {
        logic             gen;
        chan_cfg_t        cfg;
        logic [TMR_W-1:0] cnt;
        logic [TMR_W-1:0] cmp;
        logic [TMR_W-1:0] per;
        logic             status;
        logic             pulse;
    } chan_state_t;

    chan_state_t s_d, s_q;

    logic             sel_run, sel_stat, sel_cfg;
    logic             cnt_we_lo, cnt_we_hi, cnt_wr;
    logic             cmp_we_lo, cmp_we_hi, cmp_wr;
    logic [TMR_W-1:0] wdat_pos;
    logic [TMR_W-1:0] cnt_inc;
    logic             hit_raw, match;
    logic [TMR_W-1:0] cmp_reload, cmp_base, cmp_new, per_new;

    // Write decode and placement of 32-bit data into its half.
    always_comb begin
        sel_run   = bus_we && (bus_addr == ADDR_W'(OFS_RUN));
        sel_stat  = bus_we && (bus_addr == ADDR_W'(OFS_STAT));
        sel_cfg   = bus_we && (bus_addr == ADDR_W'(OFS_CFG));
        cnt_we_lo = bus_we && (bus_addr == ADDR_W'(OFS_CNT_LO));
        cnt_we_hi = bus_we && ((bus_addr == ADDR_W'(OFS_CNT_HI)) ||
                               (bus_wide && bus_addr == ADDR_W'(OFS_CNT_LO)));
        cmp_we_lo = bus_we && (bus_addr == ADDR_W'(OFS_CMP_LO));
        cmp_we_hi = bus_we && ((bus_addr == ADDR_W'(OFS_CMP_HI)) ||
                               (bus_wide && bus_addr == ADDR_W'(OFS_CMP_LO)));
        cnt_wr    = cnt_we_lo || cnt_we_hi;
        cmp_wr    = cmp_we_lo || cmp_we_hi;
        if (bus_wide)         wdat_pos = bus_wdata;
        else if (bus_addr[2]) wdat_pos = {bus_wdata[H-1:0], {H{1'b0}}};
        else                  wdat_pos = {{H{1'b0}}, bus_wdata[H-1:0]};
        cnt_inc = s_q.cnt + 1'b1;
    end

    evt_match #(.W(TMR_W)) u_match (
        .cnt_next (cnt_inc),
        .target   (s_q.cmp),
        .narrow   (s_q.cfg.mode32),
        .hit      (hit_raw)
    );

    assign match = s_q.gen && !cnt_wr && hit_raw;

    evt_reload #(.W(TMR_W)) u_reload (
        .target      (s_q.cmp),
        .period      (s_q.per),
        .narrow      (s_q.cfg.mode32),
        .target_next (cmp_reload)
    );

    assign cmp_base = (match && s_q.cfg.periodic) ? cmp_reload : s_q.cmp;

    evt_wr_merge #(.W(TMR_W), .PER_HI_MAX(PER_HI_MAX)) u_merge (
        .tgt_base (cmp_base),
        .per_base (s_q.per),
        .we_lo    (cmp_we_lo),
        .we_hi    (cmp_we_hi),
        .wdata    (wdat_pos),
        .periodic (s_q.cfg.periodic),
        .load_tgt (s_q.cfg.setval),
        .tgt_new  (cmp_new),
        .per_new  (per_new)
    );

    // Next-state computation.
    always_comb begin
        s_d       = s_q;
        s_d.pulse = match;
        if (s_q.gen) s_d.cnt = cnt_inc;
        if (cnt_we_lo) s_d.cnt[H-1:0]     = wdat_pos[H-1:0];
        if (cnt_we_hi) s_d.cnt[TMR_W-1:H] = wdat_pos[TMR_W-1:H];
        s_d.cmp = cmp_new;
        s_d.per = per_new;
        if (sel_cfg) s_d.cfg = chan_cfg_t'(bus_wdata[CFG_BITS-1:0]);
        if (cmp_wr)  s_d.cfg.setval = 1'b0;
        if (sel_run) s_d.gen = bus_wdata[0];
        if (sel_stat && bus_wdata[0]) s_d.status = 1'b0;
        if (match) s_d.status = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign irq = s_q.cfg.en && (s_q.cfg.lvl ? s_q.status : s_q.pulse);

    // Read mux.
    always_comb begin
        rd_data = '0;
        case (rd_addr)
            ADDR_W'(OFS_RUN):    rd_data = H'(s_q.gen);
            ADDR_W'(OFS_STAT):   rd_data = H'(s_q.status);
            ADDR_W'(OFS_CNT_LO): rd_data = s_q.cnt[H-1:0];
            ADDR_W'(OFS_CNT_HI): rd_data = s_q.cnt[TMR_W-1:H];
            ADDR_W'(OFS_CFG):    rd_data = H'(s_q.cfg);
            ADDR_W'(OFS_CMP_LO): rd_data = s_q.cmp[H-1:0];
            ADDR_W'(OFS_CMP_HI): rd_data = s_q.cmp[TMR_W-1:H];
            ADDR_W'(OFS_PER_LO): rd_data = s_q.per[H-1:0];
            ADDR_W'(OFS_PER_HI): rd_data = s_q.per[TMR_W-1:H];
            default:             rd_data = '0;
        endcase
    end
endmodule

// File: rtl/evt_timer_channel_chk.sv
module evt_timer_channel_chk #(
    parameter int unsigned TMR_W = 64,
    parameter logic [TMR_W/2-1:0] PER_HI_MAX = 32'h7FFF_FFFF
) (
    input logic             clk,
    input logic             rst_n,
    input logic             gen,
    input logic             periodic,
    input logic             setval,
    input logic             mode32,
    input logic             lvl,
    input logic [TMR_W-1:0] cnt,
    input logic [TMR_W-1:0] cmp,
    input logic [TMR_W-1:0] per,
    input logic             status,
    input logic             match,
    input logic             cnt_wr,
    input logic             cmp_wr,
    input logic             irq
);
    localparam int unsigned H = TMR_W / 2;

    assert_cnt_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        gen && !cnt_wr |=> cnt == $past(cnt) + 1'b1);

    assert_cnt_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !gen && !cnt_wr |=> cnt == $past(cnt));

    assert_status_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        match |=> status);

    assert_oneshot_keep_R2: assert property (@(posedge clk) disable iff (!rst_n)
        match && !periodic && !cmp_wr |=> cmp == $past(cmp));

    assert_setval_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_wr |=> !setval);

    assert_reload_R6: assert property (@(posedge clk) disable iff (!rst_n)
        match && periodic && !mode32 && !cmp_wr |=> cmp == $past(cmp) + $past(per));

    assert_pulse_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !lvl && irq |-> $past(match));

    always @(posedge clk) begin
        if (rst_n) begin
            assert_per_clamp_R7: assert (per[TMR_W-1:H] <= PER_HI_MAX);
        end
    end
endmodule

bind evt_timer_channel evt_timer_channel_chk #(
    .TMR_W(TMR_W), .PER_HI_MAX(PER_HI_MAX)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .gen      (s_q.gen),
    .periodic (s_q.cfg.periodic),
    .setval   (s_q.cfg.setval),
    .mode32   (s_q.cfg.mode32),
    .lvl      (s_q.cfg.lvl),
    .cnt      (s_q.cnt),
    .cmp      (s_q.cmp),
    .per      (s_q.per),
    .status   (s_q.status),
    .match    (match),
    .cnt_wr   (cnt_wr),
    .cmp_wr   (cmp_wr),
    .irq      (irq)
);

// File: tb/evt_timer_channel_tb.sv
module evt_timer_channel_tb;
    localparam logic [7:0] A_RUN = 8'h00, A_STAT = 8'h04, A_CNT = 8'h08, A_CNTH = 8'h0C;
    localparam logic [7:0] A_CFG = 8'h10, A_CMP = 8'h18, A_CMPH = 8'h1C, A_PER = 8'h20;
    localparam logic [31:0] C_EN = 1, C_PER = 2, C_SET = 4, C_M32 = 8, C_LVL = 16;

    logic        clk = 0, rst_n = 0;
    logic        bus_we = 0, bus_wide = 0;
    logic [7:0]  bus_addr = 0, rd_addr = 0;
    logic [63:0] bus_wdata = 0;
    logic [31:0] rd_data;
    logic        irq;
    int          n_chk = 0, n_bad = 0;
    bit          done = 0;

    always #10 clk = ~clk;

    evt_timer_channel u_dut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_wide(bus_wide),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rd_addr(rd_addr),
        .rd_data(rd_data), .irq(irq)
    );

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // Called just after a falling edge; consumes exactly one rising edge.
    task automatic wr(input logic [7:0] a, input logic [63:0] d, input logic wide);
        bus_we = 1; bus_addr = a; bus_wdata = d; bus_wide = wide;
        @(negedge clk);
        bus_we = 0; bus_wide = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        rd_addr = a; #1; v = rd_data;
    endtask

    task automatic rd64(input logic [7:0] a, output logic [63:0] v);
        logic [31:0] lo, hi;
        rd(a, lo); rd(a + 8'h4, hi); v = {hi, lo};
    endtask

    function automatic logic [63:0] exp_tgt(input logic [63:0] t, input longint unsigned p,
                                            input longint unsigned off, input longint unsigned k);
        if (k < off) return t;
        return t + p * ((k - off) / p + 1);
    endfunction

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
    end

    initial begin
        logic [63:0] v; logic [31:0] w;
        void'($urandom(32'h5EED_1234));
        idle(3); rst_n = 1; idle(1);

        // R1 reset state and counting
        rd64(A_CNT, v); chk("R1 reset counter", v, 0);
        rd(A_CFG, w); chk("R1 reset config", 64'(w), 0);
        chk("R1 reset irq", 64'(irq), 0);
        wr(A_RUN, 1, 0); idle(4); wr(A_RUN, 0, 0);
        rd64(A_CNT, v); chk("R1 counter after 5 run edges", v, 5);
        idle(3); rd64(A_CNT, v); chk("R1 counter holds when stopped", v, 5);

        // R13 counter high-word load
        wr(A_CNTH, 7, 0); rd64(A_CNT, v); chk("R13 high word load", v, 64'h7_0000_0005);

        // R2 one-shot match timing, level enabled
        wr(A_CFG, C_EN | C_LVL, 0);
        wr(A_CNT, 64'h0000_0003_0000_0100, 1);
        wr(A_CMP, 64'h0000_0003_0000_0103, 1);
        wr(A_STAT, 1, 0);
        wr(A_RUN, 1, 0); idle(2);
        rd(A_STAT, w); chk("R2 status before match", 64'(w), 0);
        idle(1);
        rd(A_STAT, w); chk("R2 status at match", 64'(w), 1);
        chk("R8 level irq follows status", 64'(irq), 1);
        wr(A_RUN, 0, 0);
        rd64(A_CMP, v); chk("R2 one-shot target kept", v, 64'h0000_0003_0000_0103);

        // R12 write-one-to-clear
        wr(A_STAT, 0, 0); rd(A_STAT, w); chk("R12 write 0 keeps status", 64'(w), 1);
        wr(A_STAT, 1, 0); rd(A_STAT, w); chk("R12 write 1 clears status", 64'(w), 0);
        chk("R8 irq drops with status", 64'(irq), 0);

        // R10 all-ones target
        wr(A_CNT, 64'hFFFF_FFFF_FFFF_FFFD, 1);
        wr(A_CMP, 64'hFFFF_FFFF_FFFF_FFFF, 1);
        wr(A_RUN, 1, 0); idle(1);
        chk("R10 no irq one before all ones", 64'(irq), 0);
        idle(1);
        chk("R10 irq at all ones", 64'(irq), 1);
        wr(A_RUN, 0, 0); wr(A_STAT, 1, 0);

        // R8 disabled channel: status sets, irq stays low
        wr(A_CFG, C_LVL, 0);
        wr(A_CNT, 64'd100, 1); wr(A_CMP, 64'd102, 1);
        wr(A_RUN, 1, 0); idle(2);
        rd(A_STAT, w); chk("R8 disabled status still sets", 64'(w), 1);
        chk("R8 disabled irq low", 64'(irq), 0);
        wr(A_RUN, 0, 0); wr(A_STAT, 1, 0);

        // R9 pulse mode
        wr(A_CFG, C_EN, 0);
        wr(A_CNT, 64'd200, 1); wr(A_CMP, 64'd202, 1);
        wr(A_RUN, 1, 0); idle(1);
        chk("R9 no pulse before match", 64'(irq), 0);
        idle(1); chk("R9 pulse at match", 64'(irq), 1);
        idle(1); chk("R9 pulse lasts one cycle", 64'(irq), 0);
        wr(A_RUN, 0, 0); wr(A_STAT, 1, 0);

        // R11 narrow matching ignores upper bits
        wr(A_CFG, C_EN | C_LVL | C_M32, 0);
        wr(A_CNT, 64'h0000_0005_FFFF_FFF0, 1);
        wr(A_CMP, 64'h0000_0000_FFFF_FFF2, 1);
        wr(A_RUN, 1, 0); idle(1);
        rd(A_STAT, w); chk("R11 narrow before match", 64'(w), 0);
        idle(1);
        rd(A_STAT, w); chk("R11 narrow match on low word", 64'(w), 1);
        wr(A_RUN, 0, 0); wr(A_STAT, 1, 0);

        // R3 periodic write without load-target
        wr(A_CFG, C_PER, 0);
        wr(A_CMP, 64'h1234, 0);
        rd64(A_CMP, v); chk("R3 target untouched", v, 64'h0000_0000_FFFF_FFF2);
        rd(A_PER, w); chk("R3 period low written", 64'(w), 64'h1234);

        // R4 load-target on a 32-bit write, then self-clear
        wr(A_CFG, C_PER | C_SET, 0);
        wr(A_CMP, 64'hAAAA_AAAA, 0);
        rd(A_CMP, w); chk("R4 target low loaded", 64'(w), 64'hAAAA_AAAA);
        rd(A_PER, w); chk("R4 period low loaded", 64'(w), 64'hAAAA_AAAA);
        rd(A_CFG, w); chk("R4 load bit cleared", 64'(w[2]), 0);
        wr(A_CMPH, 5, 0);
        rd(A_CMPH, w); chk("R4 high target untouched after clear", 64'(w), 0);
        rd(A_PER + 8'h4, w); chk("R4 high period written", 64'(w), 5);

        // R7 clamp
        wr(A_CFG, C_PER | C_SET, 0);
        wr(A_CMPH, 64'hFFFF_FFFF, 0);
        rd(A_PER + 8'h4, w); chk("R7 period high clamped", 64'(w), 64'h7FFF_FFFF);
        rd(A_CMPH, w); chk("R7 target high raw", 64'(w), 64'hFFFF_FFFF);

        // R5 wide load, R6 first match at written value then reload
        wr(A_CFG, C_PER | C_SET | C_LVL | C_EN, 0);
        wr(A_CMP, 64'h0000_0001_0000_0010, 1);
        rd64(A_CMP, v); chk("R5 wide target", v, 64'h0000_0001_0000_0010);
        rd64(A_PER, v); chk("R5 wide period", v, 64'h0000_0001_0000_0010);
        rd(A_CFG, w); chk("R5 load bit cleared after wide", 64'(w[2]), 0);
        wr(A_CMP, 64'h8, 1);
        rd64(A_PER, v); chk("R6 new period only", v, 64'h8);
        wr(A_CNT, 64'h0000_0001_0000_000D, 1);
        wr(A_STAT, 1, 0);
        wr(A_RUN, 1, 0); idle(2);
        rd(A_STAT, w); chk("R6 no early periodic match", 64'(w), 0);
        idle(1);
        rd(A_STAT, w); chk("R6 first match at written value", 64'(w), 1);
        wr(A_RUN, 0, 0);
        rd64(A_CMP, v); chk("R6 target advanced by period", v, 64'h0000_0001_0000_0018);

        // R6 random periodic runs
        for (int i = 0; i < 10; i++) begin
            logic [63:0] base, tgt;
            longint unsigned off, p, m;
            base = {$urandom, $urandom} & 64'h7FFF_FFFF_FFFF_0000;
            off  = 1 + ($urandom % 30);
            p    = 1 + ($urandom % 15);
            m    = $urandom % 60;
            tgt  = base + off;
            wr(A_CFG, C_PER | C_SET, 0);
            wr(A_CNT, base, 1);
            wr(A_CMP, tgt, 1);
            wr(A_CMP, 64'(p), 1);
            wr(A_STAT, 1, 0);
            wr(A_RUN, 1, 0); idle(int'(m)); wr(A_RUN, 0, 0);
            rd64(A_CMP, v); chk("R6 random periodic target", v, exp_tgt(tgt, p, off, m + 1));
            rd(A_STAT, w); chk("R6 random status", 64'(w), 64'((m + 1) >= off));
        end

        summary();
    end
endmodule